// File: doc/BRIEF.md
# Frame address relocation filter

This block sits in a 32-bit configuration word stream, between the memory read data and the FIFO that feeds the configuration port. It passes every word through with one register of latency and handles one word per cycle. It watches the stream for the command that writes the frame address register. The word that follows that command is a frame address. The filter replaces its row and column fields with values held on two register inputs, so that one stored module image can be loaded into a different place on the fabric. Every other field of the address word is left as it was.

Payload words can take any value, so a data word may happen to equal a command code. To keep such words from being read as commands, the filter also recognises the data-write command. The word after that command is a length. The filter then lets exactly that many following words through without comparing them against the command codes. Both sides use a valid/ready handshake. Backpressure from the downstream FIFO reaches the input ready combinationally, so the filter never drops a word and never adds a stall.

Top module: `frame_reloc_filter`

## Requirements
- R1: After reset `out_valid` is 0, and the filter is in scan mode, so the first frame-address command it sees is recognised.
- R2: When `out_ready` is 1, a word accepted on the input in one cycle appears on `out_data`, with `out_valid` high, one clock later. Words leave in the order they arrived.
- R3: A word accepted in scan mode that equals 0x30002001 is forwarded unchanged. The next accepted word is the frame address: bits [21:17] are replaced with `new_row`, bits [16:7] are replaced with `new_col`, and bits [31:22] and [6:0] are kept.
- R4: In scan mode, a word that is not a command is forwarded bit for bit unchanged.
- R5: A word accepted in scan mode that equals 0x30004000 starts a data write, and the next accepted word is a length N. The length word is forwarded unchanged. The N words after it are forwarded unchanged and are never compared against the command codes, even if one of them equals 0x30002001 or 0x30004000.
- R6: After the N-th payload word, the filter is back in scan mode, and the next frame-address command is acted on.
- R7: A length of 0 returns the filter to scan mode at once, so the word right after the length word is scanned.
- R8: `in_ready` equals `out_ready`. While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold their values.
- R9: Cycles in which no word is accepted (`in_valid` is 0, or `out_ready` is 0) do not advance the decode state. An address word that arrives after such gaps is still rewritten, and a payload count still counts only accepted words.
- R10: `new_row` and `new_col` are used as they stand in the cycle the address word is accepted, so a change between two address words applies to the second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| new_row | input | ROW_W | Row value written into relocated frame addresses |
| new_col | input | COL_W | Column value written into relocated frame addresses |
| in_valid | input | 1 | Input word present |
| in_data | input | DATA_W | Input configuration word |
| in_ready | output | 1 | Filter can take a word (follows out_ready) |
| out_valid | output | 1 | Output word present |
| out_data | output | DATA_W | Filtered configuration word |
| out_ready | input | 1 | Downstream FIFO can take a word |

## Verification
A wrong decode state shows up at the ports within a single transfer.

- If the filter wrongly believes it is in scan mode, the next address word passes through with its original row and column.
- If it wrongly believes it is in rewrite mode, an ordinary word comes out with corrupted bits [21:7].

A wrong payload count shows up later, one word past the end of the payload:

- If the count ends too early, a payload word that mimics a command causes the word after it to be rewritten.
- If the count ends too late, a real frame-address command that follows the payload is not honoured.

The directed streams place mimic words at the first and last payload positions, with gaps in the flow, so that both of these errors are exposed within a few words.

// File: rtl/frame_reloc_filter.sv
module frame_reloc_filter #(
  parameter int DATA_W   = 32,
  parameter int ROW_W    = 5,
  parameter int ROW_LSB  = 17,
  parameter int COL_W    = 10,
  parameter int COL_LSB  = 7,
  parameter int LEN_W    = 32,
  parameter logic [DATA_W-1:0] CMD_ADDR = 32'h3000_2001,
  parameter logic [DATA_W-1:0] CMD_DATA = 32'h3000_4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ROW_W-1:0]  new_row,
  input  logic [COL_W-1:0]  new_col,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready
);

  localparam int ROW_MSB = ROW_LSB + ROW_W - 1;
  localparam int COL_MSB = COL_LSB + COL_W - 1;

  typedef enum logic [1:0] {S_SCAN, S_ADDR, S_LEN, S_PAY} mode_t;

  mode_t             mode;
  logic [LEN_W-1:0]  left;
  logic [DATA_W-1:0] fixed;
  logic              take;

  assign in_ready = out_ready;
  assign take     = in_valid && out_ready;

  always_comb begin
    fixed = in_data;
    if (mode == S_ADDR) begin
      fixed[ROW_MSB:ROW_LSB] = new_row;
      fixed[COL_MSB:COL_LSB] = new_col;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= S_SCAN;
      left <= '0;
    end else if (take) begin
      case (mode)
        S_SCAN:
          if (in_data == CMD_ADDR)      mode <= S_ADDR;
          else if (in_data == CMD_DATA) mode <= S_LEN;
        S_ADDR: mode <= S_SCAN;
        S_LEN: begin
          left <= in_data[LEN_W-1:0];
          mode <= (in_data[LEN_W-1:0] == '0) ? S_SCAN : S_PAY;
        end
        default: begin
          left <= left - 1'b1;
          if (left == LEN_W'(1)) mode <= S_SCAN;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (out_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= fixed;
    end
  end

  a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |=> out_valid == $past(in_valid));

  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r3_row_col_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (take && mode == S_ADDR) |=>
      (out_data[ROW_MSB:ROW_LSB] == $past(new_row) &&
       out_data[COL_MSB:COL_LSB] == $past(new_col) &&
       out_data[DATA_W-1:ROW_MSB+1] == $past(in_data[DATA_W-1:ROW_MSB+1]) &&
       out_data[COL_LSB-1:0] == $past(in_data[COL_LSB-1:0])));

  a_r5_payload_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (take && mode == S_PAY) |=> out_data == $past(in_data));

  a_r6_count_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (take && mode == S_PAY && left == LEN_W'(1)) |=> mode == S_SCAN);

  a_r7_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    mode == S_PAY |-> left != '0);

  a_r9_idle_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(mode) && $stable(left));

endmodule

// File: tb/test_frame_reloc_filter.sv
`timescale 1ns/1ps
module test_frame_reloc_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  new_row = 5'd0;
  logic [9:0]  new_col = 10'd0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = 32'd0;
  logic        in_ready;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_ready = 1'b1;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  localparam logic [31:0] FAR_CMD = 32'h3000_2001;
  localparam logic [31:0] LEN_CMD = 32'h3000_4000;

  always #4 clk = ~clk;

  frame_reloc_filter i_frame_reloc_filter (
    .clk(clk), .rst_n(rst_n), .new_row(new_row), .new_col(new_col),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  function automatic logic [31:0] moved(input logic [31:0] w, input logic [4:0] r,
                                        input logic [9:0] c);
    return {w[31:22], r, c, w[6:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] d, input logic [31:0] exp, input string req);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check(req, out_data, exp);
  endtask

  task automatic gap(input string req);
    in_valid = 1'b0;
    in_data  = 32'h3000_2001;
    @(negedge clk);
    check({req, " gap"}, {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_reset;
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    check("R8 in_ready", {31'd0, in_ready}, {31'd0, out_ready});
  endtask

  task automatic t_plain;
    send(32'hAAAA_5555, 32'hAAAA_5555, "R4 plain");
    send(32'h0000_0000, 32'h0000_0000, "R2 order");
    send(32'h3000_2000, 32'h3000_2000, "R4 near command");
    send(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4 ones");
  endtask

  task automatic t_far;
    new_row = 5'h15; new_col = 10'h2A3;
    send(FAR_CMD, FAR_CMD, "R3 cmd");
    send(32'h03DF_FFFF, moved(32'h03DF_FFFF, 5'h15, 10'h2A3), "R3 rewrite");
    send(32'h0123_4567, 32'h0123_4567, "R3 one word only");
    send(FAR_CMD, FAR_CMD, "R3 cmd2");
    send(32'h0280_0041, moved(32'h0280_0041, 5'h15, 10'h2A3), "R3 rewrite2");
  endtask

  task automatic t_payload;
    new_row = 5'h03; new_col = 10'h011;
    send(LEN_CMD, LEN_CMD, "R5 cmd");
    send(32'd3, 32'd3, "R5 count");
    send(FAR_CMD, FAR_CMD, "R5 mimic first");
    send(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 payload not rewritten");
    send(LEN_CMD, LEN_CMD, "R5 mimic last");
    send(FAR_CMD, FAR_CMD, "R6 cmd after payload");
    send(32'h0000_0000, moved(32'h0, 5'h03, 10'h011), "R6 rewrite after payload");
  endtask

  task automatic t_zero;
    new_row = 5'h1F; new_col = 10'h3FF;
    send(LEN_CMD, LEN_CMD, "R7 cmd");
    send(32'd0, 32'd0, "R7 zero count");
    send(FAR_CMD, FAR_CMD, "R7 scanned");
    send(32'h0180_0000, moved(32'h0180_0000, 5'h1F, 10'h3FF), "R7 rewrite");
  endtask

  task automatic t_gaps;
    new_row = 5'h0A; new_col = 10'h155;
    send(FAR_CMD, FAR_CMD, "R9 cmd");
    gap("R9");
    gap("R9");
    send(32'h0000_0000, moved(32'h0, 5'h0A, 10'h155), "R9 rewrite after gaps");
    send(LEN_CMD, LEN_CMD, "R9 len cmd");
    send(32'd2, 32'd2, "R9 count");
    send(FAR_CMD, FAR_CMD, "R9 payload1");
    gap("R9");
    send(32'h1234_5678, 32'h1234_5678, "R9 payload2 untouched");
    send(FAR_CMD, FAR_CMD, "R9 scan resumes");
    send(32'h0000_0000, moved(32'h0, 5'h0A, 10'h155), "R9 rewrite resumes");
  endtask

  task automatic t_stall;
    send(32'hCAFE_F00D, 32'hCAFE_F00D, "R8 before stall");
    out_ready = 1'b0;
    in_valid = 1'b1;
    in_data = FAR_CMD;
    #1;
    check("R8 in_ready low", {31'd0, in_ready}, 32'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R8 hold valid", {31'd0, out_valid}, 32'd1);
      check("R8 hold data", out_data, 32'hCAFE_F00D);
    end
    out_ready = 1'b1;
    #1;
    check("R8 in_ready high", {31'd0, in_ready}, 32'd1);
    send(32'h4444_4444, 32'h4444_4444, "R9 stalled cmd not taken");
  endtask

  task automatic t_regs;
    new_row = 5'h01; new_col = 10'h001;
    send(FAR_CMD, FAR_CMD, "R10 cmd");
    new_row = 5'h12; new_col = 10'h234;
    send(32'h0000_0000, moved(32'h0, 5'h12, 10'h234), "R10 value at accept");
    new_row = 5'h07; new_col = 10'h0F0;
    send(FAR_CMD, FAR_CMD, "R10 cmd2");
    send(32'h0000_0000, moved(32'h0, 5'h07, 10'h0F0), "R10 new value");
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_far();
    t_plain();
    t_payload();
    t_zero();
    t_gaps();
    t_stall();
    t_regs();
    in_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule